// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer that counts ticks from a slow watchdog clock-enable input. If software does not restart the count within a programmed window, the block raises an NMI request or a system reset request. The mode field chooses which one. The timer's control and limit registers can only be changed while a separate 16-bit key register holds the unlock value. Writing any other value to that key register locks them again. This guards the timer against stray writes.

Software talks to the block through a flat register port. The port has one address bus, a write strobe, write data, and combinational read data for the addressed register.

Key register, address 0:
- Bits [15:0] hold the key, read as written.

Control register, address 1:
- Bits [3:0] are the run field.
- Bit 4 is the restart command.
- Bits [9:8] are the mode field.
- Bit 12 is the sticky NMI flag, read-only.

Limit register, address 2:
- Bits [9:0] hold the compare value.

The interrupt controller, the reset circuitry and the clock source are outside the block. The block only drives the two request outputs.

Top module: `wdog_guard`

## Requirements
- R1: Out of reset the key register reads 0 and the block is locked. Writing 0x0096 to address 0 unlocks it. Writing any other value there locks it. The key register reads back the last value written, and writes to it are accepted at all times.
- R2: While locked, writes to address 1 (control) and address 2 (limit) leave every readable field and the counter unchanged.
- R3: The run field, control bits [3:0], resets to 0xA. While it holds 0xA the timer is stopped. Any other value makes it run. While stopped, no tick advances the counter and no request is raised.
- R4: The limit register, bits [9:0] at address 2, resets to 0x3FF. A match occurs on the (limit+1)-th running tick after the counter is restarted. A limit of 639 gives a window of 640 ticks.
- R5: The counter advances only on a cycle where tick is high while running. Stopping the timer keeps the partial count, and a restart of running continues from it.
- R6: A write, while unlocked, to address 1 with bit 4 set clears the counter to 0, so a full new window starts. Bit 4 always reads back as 0.
- R7: On a match the counter returns to 0 by itself and keeps counting. Matches therefore repeat every limit+1 ticks.
- R8: The mode field, control bits [9:8], sets the action on a match. Value 00 raises an NMI. Any other value raises a reset request. The output that was not selected stays low.
- R9: An NMI match sets a sticky flag, read at control bit 12 and driven on nmi_req. Further ticks leave it at 1. Only a restart command (R6) clears it.
- R10: A reset-mode match raises rst_req on the cycle after the matching tick. rst_req drops after the next tick. With a limit of 0 every tick matches, so it stays high.
- R11: A restart command in the same cycle as a tick wins over the tick. The counter is 0 afterwards and no match occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| rdata | output | DATA_W | Read data of the addressed register |
| tick | input | 1 | Watchdog clock enable, one count per high cycle |
| nmi_req | output | 1 | NMI request level, equal to the sticky flag |
| rst_req | output | 1 | Reset request pulse |

## Verification
The bench sweeps every limit from 0 to 31, plus 639 and 1023, in all four mode codes. For each case it counts the ticks to the first request and checks that the count equals the limit plus one. A design with an off-by-one compare, or one that counts stopped ticks, would miss this count. Other corner cases:
- Locked writes and near-miss key values are tried. A design that decodes the key loosely would let such writes land.
- A limit of 0 is tried, where a reset request must stay high on every tick.
- A restart command is issued in the same cycle as a tick. A design that lets the tick win would leave the count at 1 and shorten the next window.
- The timer is stopped partway through a window and then restarted. A design that cleared the count on stop would stretch the window; one that kept counting would shorten it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int KEY_W  = 16;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h0096;

    localparam int RUN_W  = 4;
    localparam logic [RUN_W-1:0] STOP_CODE = 4'hA;

    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_NMI = 2'b00;

    // control register field positions
    localparam int RUN_LSB  = 0;
    localparam int CLR_BIT  = 4;
    localparam int MODE_LSB = 8;
    localparam int STS_BIT  = 12;

    // register selects
    localparam int SEL_KEY   = 0;
    localparam int SEL_CTRL  = 1;
    localparam int SEL_LIMIT = 2;
endpackage

// File: rtl/wdog_keylock.sv
module wdog_keylock
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [KEY_W-1:0]  key_o,
    output logic              unlocked_o
);
    typedef struct packed {
        logic [KEY_W-1:0] key;
    } lock_t;

    lock_t lk_d, lk_q;
    logic  key_hit;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        key_hit = wr_en && (addr == ADDR_W'(SEL_KEY));
        lk_d    = lk_q;
        if (key_hit) begin
            lk_d.key = wdata[KEY_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign key_o      = lk_q.key;
    assign unlocked_o = (lk_q.key == UNLOCK_KEY);

    // R1
    key_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |=> (unlocked_o == ($past(wdata[KEY_W-1:0]) == UNLOCK_KEY)));

    // R1
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_hit |=> $stable(unlocked_o));
endmodule

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              unlocked_i,
    output logic [RUN_W-1:0]  run_field_o,
    output logic              running_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [CMP_W-1:0]  cmp_o,
    output logic              clr_o
);
    typedef struct packed {
        logic [RUN_W-1:0]  run;
        logic [MODE_W-1:0] mode;
        logic [CMP_W-1:0]  cmp;
    } ctl_t;

    ctl_t cr_d, cr_q;
    logic wr_ok;
    logic ctrl_hit;
    logic lim_hit;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        wr_ok    = wr_en && unlocked_i;
        ctrl_hit = wr_ok && (addr == ADDR_W'(SEL_CTRL));
        lim_hit  = wr_ok && (addr == ADDR_W'(SEL_LIMIT));
        cr_d     = cr_q;
        if (ctrl_hit) begin
            cr_d.run  = wdata[RUN_LSB +: RUN_W];
            cr_d.mode = wdata[MODE_LSB +: MODE_W];
        end
        if (lim_hit) begin
            cr_d.cmp = wdata[CMP_W-1:0];
        end
        clr_o = ctrl_hit && wdata[CLR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_q.run  <= STOP_CODE;
            cr_q.mode <= MODE_NMI;
            cr_q.cmp  <= '1;
        end else begin
            cr_q <= cr_d;
        end
    end

    assign run_field_o = cr_q.run;
    assign running_o   = (cr_q.run != STOP_CODE);
    assign mode_o      = cr_q.mode;
    assign cmp_o       = cr_q.cmp;

    // R2
    locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked_i) |=> ($stable(run_field_o) && $stable(mode_o) && $stable(cmp_o)));

    // R3
    stop_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && (wdata[RUN_LSB +: RUN_W] == STOP_CODE)) |=> !running_o);

    // R3
    start_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && (wdata[RUN_LSB +: RUN_W] != STOP_CODE)) |=> running_o);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int CMP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              running,
    input  logic              clr,
    input  logic [CMP_W-1:0]  cmp,
    input  logic [MODE_W-1:0] mode,
    output logic              nmi_o,
    output logic              rst_o
);
    typedef struct packed {
        logic [CMP_W-1:0] cnt;
        logic             nmi;
        logic             rst;
    } cnt_t;

    cnt_t ct_d, ct_q;
    logic match;

    always_comb begin
        ct_d  = ct_q;
        match = 1'b0;
        if (clr) begin
            ct_d.cnt = '0;
            ct_d.nmi = 1'b0;
        end else if (tick && running) begin
            if (ct_q.cnt == cmp) begin
                ct_d.cnt = '0;
                match    = 1'b1;
            end else begin
                ct_d.cnt = ct_q.cnt + 1'b1;
            end
        end
        if (tick) begin
            ct_d.rst = 1'b0;
        end
        if (match) begin
            if (mode == MODE_NMI) begin
                ct_d.nmi = 1'b1;
            end else begin
                ct_d.rst = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign nmi_o = ct_q.nmi;
    assign rst_o = ct_q.rst;

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(tick && running)) |=> $stable(ct_q.cnt));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && tick && running && (ct_q.cnt == cmp)) |=> (ct_q.cnt == '0));

    // R11
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((ct_q.cnt == '0) && !nmi_o));

    // R9
    nmi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_o) |-> $past(clr));

    // R8
    nmi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> ($past(mode) == MODE_NMI));

    // R10
    rst_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> $past(tick && running));
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick,
    output logic              nmi_req,
    output logic              rst_req
);
    logic [KEY_W-1:0]  key;
    logic              unlocked;
    logic [RUN_W-1:0]  run_field;
    logic              running;
    logic [MODE_W-1:0] mode;
    logic [CMP_W-1:0]  cmp;
    logic              clr;

    wdog_keylock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .key_o      (key),
        .unlocked_o (unlocked)
    );

    wdog_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .unlocked_i  (unlocked),
        .run_field_o (run_field),
        .running_o   (running),
        .mode_o      (mode),
        .cmp_o       (cmp),
        .clr_o       (clr)
    );

    wdog_count #(.CMP_W(CMP_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .running (running),
        .clr     (clr),
        .cmp     (cmp),
        .mode    (mode),
        .nmi_o   (nmi_req),
        .rst_o   (rst_req)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(SEL_KEY): begin
                rdata[KEY_W-1:0] = key;
            end
            ADDR_W'(SEL_CTRL): begin
                rdata[RUN_LSB +: RUN_W]   = run_field;
                rdata[MODE_LSB +: MODE_W] = mode;
                rdata[STS_BIT]            = nmi_req;
            end
            ADDR_W'(SEL_LIMIT): begin
                rdata[CMP_W-1:0] = cmp;
            end
            default: rdata = '0;
        endcase
    end

    // R9
    nmi_flag_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(SEL_CTRL)) |-> (rdata[STS_BIT] == nmi_req));

    // R6
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(SEL_CTRL)) |-> !rdata[CLR_BIT]);
endmodule

// File: tb/sim_wdog_guard.sv
module sim_wdog_guard;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int CMP_W  = 10;
    localparam int A_KEY = 0, A_CTRL = 1, A_LIMIT = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              tick = 1'b0;
    logic              nmi_req;
    logic              rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rdata(rdata), .tick(tick), .nmi_req(nmi_req), .rst_req(rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        addr  = ADDR_W'(a);
        wdata = DATA_W'(d);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        addr = ADDR_W'(a);
        #1;
        v = int'(rdata);
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    // ticks until the selected request is seen; returns limit+1 if never
    task automatic count_until(input bit want_nmi, input int limit, output int n);
        n = 0;
        while (n <= limit) begin
            do_tick();
            n++;
            if (want_nmi ? nmi_req : rst_req) break;
        end
    endtask

    function automatic int ctrl_word(input int run, input int mode, input bit clr);
        return (run & 15) | ((mode & 3) << 8) | (clr ? 16 : 0);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int n;
        int cmp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R9 nmi after reset", int'(nmi_req), 0);
        chk("R10 rst after reset", int'(rst_req), 0);
        rd(A_KEY, v);   chk("R1 key reset", v, 0);
        rd(A_CTRL, v);  chk("R3 ctrl reset", v, 'h000A);
        rd(A_LIMIT, v); chk("R4 limit reset", v, 'h3FF);
        ticks(1100);
        chk("R3 stopped no nmi", int'(nmi_req), 0);
        chk("R3 stopped no rst", int'(rst_req), 0);

        // locked writes ignored
        wr(A_CTRL, ctrl_word(5, 1, 1'b1));
        wr(A_LIMIT, 5);
        rd(A_CTRL, v);  chk("R2 locked ctrl", v, 'h000A);
        rd(A_LIMIT, v); chk("R2 locked limit", v, 'h3FF);
        wr(A_KEY, 'h0097);
        rd(A_KEY, v);   chk("R1 key readback", v, 'h0097);
        wr(A_LIMIT, 7);
        rd(A_LIMIT, v); chk("R1 near key stays locked", v, 'h3FF);
        wr(A_KEY, 'h8096);
        wr(A_CTRL, ctrl_word(3, 0, 1'b0));
        rd(A_CTRL, v);  chk("R1 high-bit key stays locked", v, 'h000A);
        wr(A_KEY, 'h0096);
        wr(A_LIMIT, 7);
        rd(A_LIMIT, v); chk("R1 unlocked limit write", v, 7);
        wr(A_KEY, 'h0000);
        wr(A_LIMIT, 9);
        rd(A_LIMIT, v); chk("R1 relock", v, 7);

        // sweep of limits and modes
        for (int idx = 0; idx < 34; idx++) begin
            cmp = (idx < 32) ? idx : ((idx == 32) ? 639 : 1023);
            for (int mode = 0; mode < 4; mode++) begin
                wr(A_KEY, 'h0096);
                wr(A_LIMIT, cmp);
                wr(A_CTRL, ctrl_word(5, mode, 1'b1));
                count_until(mode == 0, 1100, n);
                // 639 gives the 640-tick window
                chk("R4 window length", n, cmp + 1);
                if (mode == 0) begin
                    chk("R8 nmi mode no reset", int'(rst_req), 0);
                    do_tick();
                    chk("R9 nmi sticky", int'(nmi_req), 1);
                    rd(A_CTRL, v);
                    chk("R9 flag bit 12", (v >> 12) & 1, 1);
                    wr(A_CTRL, ctrl_word(5, 0, 1'b1));
                    chk("R9 cleared by restart", int'(nmi_req), 0);
                    rd(A_CTRL, v);
                    chk("R6 restart bit reads 0", (v >> 4) & 1, 0);
                    count_until(1'b1, 1100, n);
                    chk("R6 full window after restart", n, cmp + 1);
                end else begin
                    chk("R8 reset mode no nmi", int'(nmi_req), 0);
                    do_tick();
                    chk("R10 pulse width", int'(rst_req), (cmp == 0) ? 1 : 0);
                    if (cmp > 0) begin
                        count_until(1'b0, 1100, n);
                        chk("R7 auto restart period", n, cmp);
                    end
                end
                wr(A_CTRL, ctrl_word('hA, 0, 1'b1));
                wr(A_KEY, 0);
            end
        end

        // stop keeps partial count
        wr(A_KEY, 'h0096);
        wr(A_LIMIT, 9);
        wr(A_CTRL, ctrl_word(5, 0, 1'b1));
        ticks(4);
        wr(A_CTRL, ctrl_word('hA, 0, 1'b0));
        ticks(30);
        chk("R5 stopped holds", int'(nmi_req), 0);
        wr(A_CTRL, ctrl_word(3, 0, 1'b0));
        count_until(1'b1, 100, n);
        chk("R5 resume from partial", n, 6);

        // restart mid-window
        wr(A_CTRL, ctrl_word(5, 0, 1'b1));
        ticks(7);
        wr(A_CTRL, ctrl_word(5, 0, 1'b1));
        count_until(1'b1, 100, n);
        chk("R6 mid-window restart", n, 10);

        // restart and tick in one cycle
        wr(A_LIMIT, 3);
        wr(A_CTRL, ctrl_word(5, 0, 1'b1));
        ticks(3);
        addr  = ADDR_W'(A_CTRL);
        wdata = DATA_W'(ctrl_word(5, 0, 1'b1));
        wr_en = 1'b1;
        tick  = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        tick  = 1'b0;
        chk("R11 no match on collision", int'(nmi_req), 0);
        count_until(1'b1, 100, n);
        chk("R11 restart wins", n, 4);

        // locked restart ignored
        wr(A_KEY, 'h1234);
        do_tick();
        chk("R2 flag set", int'(nmi_req), 1);
        wr(A_CTRL, ctrl_word(5, 0, 1'b1));
        chk("R2 locked restart ignored", int'(nmi_req), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule